// File: doc/BRIEF.md
# Decoupled Store Pipeline for a Two-Way Data Cache

This block is the write path of a small set-associative data cache. A store is never written into the data array in the same cycle its tag is read. It first passes a tag-check stage, which compares the store's tag against every way of its set. Only when exactly one way matches does the store move to a data-write stage. In that stage it updates the selected bytes of the matching way and no other way.

The two stages overlap. In any cycle the tag check of one store runs alongside the data write of the store before it, so back-to-back hitting stores are accepted at one per cycle. A load looks up tags and data of all ways in parallel and keeps the data of the way that matched. If the store sitting in the write stage targets the same word, the load takes that store's enabled bytes in place of the array bytes.

A store that misses holds the tag-check stage and stops accepting new stores. Once the write stage has drained, the block asks for the missing line. When the fill arrives, the line is installed and the store repeats its tag check. The array is modelled in the block as 64 sets of two ways, with one 32-bit word per line.

Top module: `store_pipe`

## Requirements
- R1: After reset no line is valid: loads miss, `st_ready` is 1, and `fill_req`, `dwr_en` and `tag_match` are all 0.
- R2: An address splits into index = bits [5:0] and tag = bits [13:6]. While a store occupies the tag-check stage, `tag_match` bit w is 1 exactly when way w of its set is valid and holds its tag. With no store there, `tag_match` is 0.
- R3: A store that hits in cycle n writes the data array in cycle n+1. In that cycle `dwr_en` is one-hot on the way that matched in cycle n, and only the bytes whose `st_be` bit is set (bit b covers data bits [8b+7:8b]) change.
- R4: When the store in the tag-check stage hits, or the stage is empty, `st_ready` is 1 and a new store is taken in the same cycle the previous store is being written.
- R5: When the store in the tag-check stage misses, `st_ready` is 0. The store stays in the stage and new stores are not taken.
- R6: `fill_req` is 1 with `fill_addr` equal to the missing store's address only while that store misses and no write is pending. A cycle with both `fill_req` and `fill_valid` high installs `fill_data` with the store's tag. The victim is the lowest-numbered invalid way of the set; if both ways are valid, the victim is the set's pointer. After a fill into way w, the pointer is w+1 mod 2, and it is 0 after reset. The store hits on the next cycle.
- R7: `fill_valid` while `fill_req` is 0 changes no line.
- R8: `ld_hit` is 1 when `ld_valid` is 1 and a valid way holds the load's tag. `ld_data` is then that way's word; words from non-matching ways are discarded. On a miss, or with `ld_valid` at 0, `ld_hit` and `ld_data` are 0.
- R9: When the write stage holds a store to the load's address, each load byte whose store byte enable is set comes from that store. All other bytes come from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_addr | input | 14 | Store word address (tag, index) |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store taken this cycle |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 14 | Load word address |
| ld_hit | output | 1 | Load found its line |
| ld_data | output | 32 | Load data, with bypass applied |
| tag_match | output | 2 | Per-way tag compare of the checked store |
| dwr_en | output | 2 | Per-way data-array write enable |
| fill_req | output | 1 | Request for the missing line |
| fill_addr | output | 14 | Address of the missing line |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 32 | Fill word |

## Verification
The hardest case to reach is a load that reads a word in the same cycle the write stage is changing it, with only some bytes enabled. A second hard case is a fill that must evict a valid line while the replacement pointer has been moved by earlier fills. The stimulus draws addresses from four tags over four sets. This keeps two-way sets overflowing, so misses and evictions are frequent. About half of the loads reuse the most recent store address, so loads often meet a store in the write stage with random byte enables. Fill responses come after random delays, and stray fill strobes are sent while no request is pending.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int unsigned TAG_BITS_DEF  = 8;
    localparam int unsigned IDX_BITS_DEF  = 6;
    localparam int unsigned WAYS_DEF      = 2;
    localparam int unsigned WORD_BITS_DEF = 32;
endpackage

// File: rtl/stp_tag_array.sv
module stp_tag_array #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 6,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic [TAG_W-1:0] chk_tag,
    output logic [WAYS-1:0]  chk_match,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [TAG_W-1:0] ld_tag,
    output logic [WAYS-1:0]  ld_match,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    output logic [WAY_W-1:0] fill_way
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [WAYS][SETS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] victim;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign chk_match[w] = vld_q[chk_idx][w] && (tag_q[w][chk_idx] == chk_tag);
        assign ld_match[w]  = vld_q[ld_idx][w]  && (tag_q[w][ld_idx]  == ld_tag);
    end

    always_comb begin
        victim = ptr_q[fill_idx];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[fill_idx][w]) victim = WAY_W'(w);
        end
    end
    assign fill_way = victim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else if (fill_en) begin
            vld_q[fill_idx][victim] <= 1'b1;
            ptr_q[fill_idx]         <= victim + WAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[victim][fill_idx] <= fill_tag;
    end
endmodule

// File: rtl/stp_data_array.sv
module stp_data_array #(
    parameter int IDX_W  = 6,
    parameter int WAYS   = 2,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                        clk,
    input  logic [WAYS-1:0]             wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [BE_W-1:0]             wr_be,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [WAYS-1:0]             fl_en,
    input  logic [IDX_W-1:0]            fl_idx,
    input  logic [DATA_W-1:0]           fl_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][DATA_W-1:0] rd_words
);
    localparam int SETS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [WAYS][SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_words[w] = mem_q[w][rd_idx];
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (fl_en[w]) mem_q[w][fl_idx] <= fl_data;
            if (wr_en[w]) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b]) mem_q[w][wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/stp_byte_merge.sv
module stp_byte_merge #(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] over,
    input  logic [BE_W-1:0]   sel,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign merged[b*8 +: 8] = sel[b] ? over[b*8 +: 8] : base[b*8 +: 8];
    end
endmodule

// File: rtl/store_pipe.sv
module store_pipe
    import stp_pkg::*;
#(
    parameter int TAG_W  = TAG_BITS_DEF,
    parameter int IDX_W  = IDX_BITS_DEF,
    parameter int WAYS   = WAYS_DEF,
    parameter int DATA_W = WORD_BITS_DEF,
    localparam int ADDR_W = TAG_W + IDX_W,
    localparam int BE_W   = DATA_W / 8,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic [WAYS-1:0]   tag_match,
    output logic [WAYS-1:0]   dwr_en,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [BE_W-1:0]   be;
    } chk_t;

    typedef struct packed {
        logic              v;
        logic [WAY_W-1:0]  way;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [BE_W-1:0]   be;
    } wr_t;

    typedef struct packed {
        chk_t chk;
        wr_t  wr;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [WAYS-1:0]             chk_match, ld_match, fl_onehot;
    logic [WAY_W-1:0]            fill_way, hit_way;
    logic [WAYS-1:0][DATA_W-1:0] rd_words;
    logic [DATA_W-1:0]           arr_word, merged;
    logic [BE_W-1:0]             byp_be;
    logic                        s1_hit, fill_go;

    stp_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_idx   (pipe_q.chk.a[IDX_W-1:0]),
        .chk_tag   (pipe_q.chk.a[ADDR_W-1:IDX_W]),
        .chk_match (chk_match),
        .ld_idx    (ld_addr[IDX_W-1:0]),
        .ld_tag    (ld_addr[ADDR_W-1:IDX_W]),
        .ld_match  (ld_match),
        .fill_en   (fill_go),
        .fill_idx  (pipe_q.chk.a[IDX_W-1:0]),
        .fill_tag  (pipe_q.chk.a[ADDR_W-1:IDX_W]),
        .fill_way  (fill_way)
    );

    stp_data_array #(.IDX_W(IDX_W), .WAYS(WAYS), .DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .wr_en    (dwr_en),
        .wr_idx   (pipe_q.wr.a[IDX_W-1:0]),
        .wr_be    (pipe_q.wr.be),
        .wr_data  (pipe_q.wr.d),
        .fl_en    (fl_onehot),
        .fl_idx   (pipe_q.chk.a[IDX_W-1:0]),
        .fl_data  (fill_data),
        .rd_idx   (ld_addr[IDX_W-1:0]),
        .rd_words (rd_words)
    );

    stp_byte_merge #(.DATA_W(DATA_W)) u_merge (
        .base   (arr_word),
        .over   (pipe_q.wr.d),
        .sel    (byp_be),
        .merged (merged)
    );

    always_comb begin
        s1_hit  = pipe_q.chk.v && (|chk_match);
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (chk_match[w]) hit_way = WAY_W'(w);
        end
        st_ready  = !pipe_q.chk.v || s1_hit;
        fill_req  = pipe_q.chk.v && !(|chk_match) && !pipe_q.wr.v;
        fill_go   = fill_req && fill_valid;
        fill_addr = pipe_q.chk.a;
        tag_match = pipe_q.chk.v ? chk_match : '0;

        for (int w = 0; w < WAYS; w++) begin
            dwr_en[w]    = pipe_q.wr.v && (pipe_q.wr.way == WAY_W'(w));
            fl_onehot[w] = fill_go && (fill_way == WAY_W'(w));
        end

        pipe_d        = pipe_q;
        pipe_d.wr.v   = s1_hit;
        pipe_d.wr.way = hit_way;
        pipe_d.wr.a   = pipe_q.chk.a;
        pipe_d.wr.d   = pipe_q.chk.d;
        pipe_d.wr.be  = pipe_q.chk.be;
        if (st_ready) begin
            pipe_d.chk.v  = st_valid;
            pipe_d.chk.a  = st_addr;
            pipe_d.chk.d  = st_data;
            pipe_d.chk.be = st_be;
        end
    end

    always_comb begin
        arr_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ld_match[w]) arr_word = arr_word | rd_words[w];
        end
        byp_be = (pipe_q.wr.v && (pipe_q.wr.a == ld_addr)) ? pipe_q.wr.be : '0;
    end

    assign ld_hit  = ld_valid && (|ld_match);
    assign ld_data = ld_hit ? merged : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
    parameter int WAYS = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_ready,
    input logic [WAYS-1:0] tag_match,
    input logic [WAYS-1:0] dwr_en,
    input logic            fill_req
);
    assert_match_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tag_match));

    assert_write_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dwr_en));

    assert_write_follows_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_en != '0) |-> (dwr_en == $past(tag_match)));

    assert_stall_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ready && !$past(st_ready)) |-> (dwr_en == '0));

    assert_fill_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (dwr_en == '0));

    assert_fill_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !st_ready);
endmodule

bind store_pipe stp_checker #(.WAYS(WAYS)) u_stp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_ready  (st_ready),
    .tag_match (tag_match),
    .dwr_en    (dwr_en),
    .fill_req  (fill_req)
);

// File: tb/sim_store_pipe.sv
module sim_store_pipe;
    localparam int AW = 14;
    localparam int DW = 32;
    localparam int NCYC = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [3:0]    st_be = '0;
    logic          st_ready;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic [1:0]    tag_match, dwr_en;
    logic          fill_req;
    logic [AW-1:0] fill_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;

    always #2 clk = ~clk;

    store_pipe u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .tag_match(tag_match), .dwr_en(dwr_en),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    // behavioural reference state
    logic [7:0]    m_tag [2][64];
    logic          m_val [2][64];
    logic [DW-1:0] m_dat [2][64];
    logic          m_ptr [64];
    logic          m1_v = 1'b0;
    logic [AW-1:0] m1_a;
    logic [DW-1:0] m1_d;
    logic [3:0]    m1_be;
    logic          m2_v = 1'b0;
    int            m2_way;
    logic [AW-1:0] m2_a;
    logic [DW-1:0] m2_d;
    logic [3:0]    m2_be;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic int find_way(input logic [AW-1:0] a);
        for (int w = 0; w < 2; w++)
            if (m_val[w][a[5:0]] && m_tag[w][a[5:0]] == a[13:6]) return w;
        return -1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 64; s++) m_val[w][s] = 1'b0;
        for (int s = 0; s < 64; s++) m_ptr[s] = 1'b0;
    end

    // reference update at each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            int  hw;
            bit  rdy, freq;
            int  vic;
            hw   = m1_v ? find_way(m1_a) : -1;
            rdy  = !m1_v || (hw >= 0);
            freq = m1_v && (hw < 0) && !m2_v;
            if (m2_v)
                for (int b = 0; b < 4; b++)
                    if (m2_be[b]) m_dat[m2_way][m2_a[5:0]][b*8 +: 8] = m2_d[b*8 +: 8];
            if (freq && fill_valid) begin
                if (!m_val[0][m1_a[5:0]])      vic = 0;
                else if (!m_val[1][m1_a[5:0]]) vic = 1;
                else                           vic = m_ptr[m1_a[5:0]];
                m_tag[vic][m1_a[5:0]] = m1_a[13:6];
                m_val[vic][m1_a[5:0]] = 1'b1;
                m_dat[vic][m1_a[5:0]] = fill_data;
                m_ptr[m1_a[5:0]]      = (vic == 0);
            end
            m2_v = m1_v && (hw >= 0);
            m2_way = hw; m2_a = m1_a; m2_d = m1_d; m2_be = m1_be;
            if (rdy) begin
                m1_v = st_valid; m1_a = st_addr; m1_d = st_data; m1_be = st_be;
            end
        end
    end

    task automatic compare_all(input bit stray_prev);
        int          hw, lw;
        bit          e_ready, e_freq, byp;
        logic [1:0]  e_match, e_wr;
        logic [DW-1:0] e_ld;
        hw      = m1_v ? find_way(m1_a) : -1;
        e_ready = !m1_v || (hw >= 0);
        e_freq  = m1_v && (hw < 0) && !m2_v;
        e_match = (hw >= 0) ? (2'b01 << hw) : 2'b00;
        e_wr    = m2_v ? (2'b01 << m2_way) : 2'b00;
        chk(e_ready ? "R4" : "R5", "st_ready", 64'(st_ready), 64'(e_ready));
        chk("R6", "fill_req", 64'(fill_req), 64'(e_freq));
        if (e_freq) chk("R6", "fill_addr", 64'(fill_addr), 64'(m1_a));
        chk("R2", "tag_match", 64'(tag_match), 64'(e_match));
        if (stray_prev) chk("R7", "tag_match after stray fill", 64'(tag_match), 64'(e_match));
        chk("R3", "dwr_en", 64'(dwr_en), 64'(e_wr));
        lw   = find_way(ld_addr);
        e_ld = '0;
        byp  = 0;
        if (ld_valid && lw >= 0) begin
            e_ld = m_dat[lw][ld_addr[5:0]];
            if (m2_v && m2_a == ld_addr) begin
                byp = (m2_be != 0);
                for (int b = 0; b < 4; b++)
                    if (m2_be[b]) e_ld[b*8 +: 8] = m2_d[b*8 +: 8];
            end
        end
        chk("R8", "ld_hit", 64'(ld_hit), 64'(ld_valid && lw >= 0));
        chk(byp ? "R9" : "R8", "ld_data", 64'(ld_data), 64'(e_ld));
    endtask

    initial begin
        int          fdelay;
        bit          stray;
        logic [AW-1:0] last_st;
        fdelay  = 1;
        stray   = 0;
        last_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ld_valid = 1'b1;
        ld_addr  = 14'h0005;
        #1;
        // R1: reset state
        chk("R1", "st_ready", 64'(st_ready), 64'd1);
        chk("R1", "fill_req", 64'(fill_req), 64'd0);
        chk("R1", "dwr_en", 64'(dwr_en), 64'd0);
        chk("R1", "tag_match", 64'(tag_match), 64'd0);
        chk("R1", "ld_hit", 64'(ld_hit), 64'd0);
        for (int c = 0; c < NCYC; c++) begin
            bit stray_prev;
            @(negedge clk);
            stray_prev = stray;
            stray = 0;
            if (fill_req) begin
                if (fdelay == 0) begin
                    fill_valid = 1'b1;
                    fdelay = $urandom % 3;
                end else begin
                    fill_valid = 1'b0;
                    fdelay--;
                end
            end else begin
                fill_valid = (($urandom % 8) == 0);
                stray = fill_valid;
            end
            fill_data = $urandom;
            st_valid  = (($urandom % 4) != 0);
            st_addr   = {6'(0), 2'($urandom % 4), 4'(0), 2'($urandom % 4)};
            st_data   = $urandom;
            st_be     = 4'($urandom);
            ld_valid  = (($urandom % 4) != 0);
            ld_addr   = ($urandom % 2) ? last_st
                                       : {6'(0), 2'($urandom % 4), 4'(0), 2'($urandom % 4)};
            if (st_valid && st_ready) last_st = st_addr;
            #1;
            compare_all(stray_prev);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule